// File: doc/BRIEF.md
# Run-Length Monitor with End-Marker Detection

This block watches the data-memory write port of a small soft processor without touching its traffic. While a run-enable input is high, which is normally tied to the core's instruction-fetch enable, it counts clock cycles. It stops counting when the core stores a fixed end-marker word to a fixed end address. The frozen count and a done flag stay on registered outputs so that a host can read how long the program ran.

The monitor also keeps a copy of the last full-word store to a result address. It raises one flag when that stored word is the success code and another when it is the failure code. A host can therefore read the verdict of a self-checking program and its run time from the same place.

Dropping run-enable clears the count and the done flag. This lets a new run be measured without a reset.

Top module: `run_len_monitor`

## Requirements
- R1: After reset, `cycle_count` is 0, `done` is 0 and `status_valid`, `status_pass` and `status_fail` are 0.
- R2: On every rising edge where `run_en` is 1 and `done` is 0, `cycle_count` goes up by exactly one. This includes the edge on which the end marker is seen.
- R3: An end match is a cycle with `run_en`=1, `wr_en`=1, all bits of `wr_be` set, `wr_addr` equal to 0x0000_2000 and `wr_data` equal to 0xDEADBEEF. `done` becomes 1 on the rising edge that samples that cycle.
- R4: A cycle with `wr_en`=0, with any `wr_be` bit clear, with a different address or with different data never sets `done`.
- R5: Once `done` is 1 and `run_en` stays 1, `cycle_count` and `done` hold. This is true even if the end marker is written again.
- R6: A rising edge that samples `run_en`=0 sets `cycle_count` to 0 and `done` to 0.
- R7: `cycle_count` saturates at 2^CNT_W-1 and never wraps to zero while counting.
- R8: A write with `wr_en`=1 and all byte enables set to address 0x0000_2004 loads `status_word` with `wr_data` and sets `status_valid`. A write there with any byte enable clear leaves both unchanged.
- R9: `status_pass` is 1 exactly when `status_valid` is 1 and `status_word` is 0xCADEBABE. `status_fail` is 1 exactly when `status_valid` is 1 and `status_word` is 0xBAAAAAAD.
- R10: An end-marker write while `run_en` is 0 leaves `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; high while the measured program runs |
| wr_en | input | 1 | Snooped memory write strobe |
| wr_addr | input | ADDR_W | Snooped byte address |
| wr_be | input | DATA_W/8 | Snooped byte enables |
| wr_data | input | DATA_W | Snooped write data |
| cycle_count | output | CNT_W | Measured run length in cycles |
| done | output | 1 | End marker seen in this run |
| status_word | output | DATA_W | Last full-word store to the result address |
| status_valid | output | 1 | A status word has been captured |
| status_pass | output | 1 | Captured word is the success code |
| status_fail | output | 1 | Captured word is the failure code |

## Verification
The end-detect path is driven with near-miss stores first: a read cycle that carries the marker at the end address, partial byte-enable stores of the marker, the marker at a neighbouring address, and another value at the end address. Each one differs from a true match in a single field, so a decoder that ignores that field shows up. A true match then checks that the count includes the match edge, and a repeated marker checks that the frozen value holds. Further patterns drop run-enable, write the marker while idle, and start a fresh run. A narrow second instance reaches saturation, and the success code, the failure code and a partial store test the status capture.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

   localparam logic [31:0] DEF_END_ADDR    = 32'h0000_2000;
   localparam logic [31:0] DEF_END_WORD    = 32'hDEAD_BEEF;
   localparam logic [31:0] DEF_RESULT_ADDR = 32'h0000_2004;
   localparam logic [31:0] DEF_PASS_WORD   = 32'hCADE_BABE;
   localparam logic [31:0] DEF_FAIL_WORD   = 32'hBAAA_AAAD;

   typedef enum logic [1:0] {
      RUN_IDLE    = 2'd0,
      RUN_COUNT   = 2'd1,
      RUN_STOPPED = 2'd2
   } run_state_e;

endpackage

// File: rtl/rlm_write_decode.sv
module rlm_write_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] END_ADDR    = rlm_pkg::DEF_END_ADDR[ADDR_W-1:0],
   parameter logic [DATA_W-1:0] END_WORD    = rlm_pkg::DEF_END_WORD[DATA_W-1:0],
   parameter logic [ADDR_W-1:0] RESULT_ADDR = rlm_pkg::DEF_RESULT_ADDR[ADDR_W-1:0],
   localparam int unsigned BE_W = DATA_W / 8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic              end_hit,
   output logic              result_hit
);

   logic [BE_W-1:0] lane_on;
   logic            full_word;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_on[g] = wr_be[g];
   end

   assign full_word  = wr_en && (&lane_on);
   assign end_hit    = full_word && (wr_addr == END_ADDR) && (wr_data == END_WORD);
   assign result_hit = full_word && (wr_addr == RESULT_ADDR);

endmodule

// File: rtl/rlm_sat_counter.sv
module rlm_sat_counter #(
   parameter int unsigned CNT_W = 32,
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/rlm_status_reg.sv
module rlm_status_reg #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] PASS_WORD = rlm_pkg::DEF_PASS_WORD[DATA_W-1:0],
   parameter logic [DATA_W-1:0] FAIL_WORD = rlm_pkg::DEF_FAIL_WORD[DATA_W-1:0]
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] word,
   output logic              valid,
   output logic              pass,
   output logic              fail
);

   logic [DATA_W-1:0] word_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         word_q  <= din;
         valid_q <= 1'b1;
      end
   end

   assign word  = word_q;
   assign valid = valid_q;
   assign pass  = valid_q && (word_q == PASS_WORD);
   assign fail  = valid_q && (word_q == FAIL_WORD);

endmodule

// File: rtl/run_len_monitor.sv
module run_len_monitor #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [ADDR_W-1:0] END_ADDR    = rlm_pkg::DEF_END_ADDR[ADDR_W-1:0],
   parameter logic [DATA_W-1:0] END_WORD    = rlm_pkg::DEF_END_WORD[DATA_W-1:0],
   parameter logic [ADDR_W-1:0] RESULT_ADDR = rlm_pkg::DEF_RESULT_ADDR[ADDR_W-1:0],
   parameter logic [DATA_W-1:0] PASS_WORD   = rlm_pkg::DEF_PASS_WORD[DATA_W-1:0],
   parameter logic [DATA_W-1:0] FAIL_WORD   = rlm_pkg::DEF_FAIL_WORD[DATA_W-1:0],
   localparam int unsigned BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cycle_count,
   output logic              done,
   output logic [DATA_W-1:0] status_word,
   output logic              status_valid,
   output logic              status_pass,
   output logic              status_fail
);

   if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_data_w
      $error("run_len_monitor: DATA_W must be a non-zero multiple of 8");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("run_len_monitor: CNT_W must be at least 2");
   end
   if (END_ADDR == RESULT_ADDR) begin : g_bad_addr
      $error("run_len_monitor: end and result addresses must differ");
   end

   rlm_pkg::run_state_e state_q, state_d;
   logic end_hit;
   logic result_hit;

   rlm_write_decode #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .END_ADDR   (END_ADDR),
      .END_WORD   (END_WORD),
      .RESULT_ADDR(RESULT_ADDR)
   ) u_decode (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .wr_data   (wr_data),
      .end_hit   (end_hit),
      .result_hit(result_hit)
   );

   always_comb begin
      state_d = state_q;
      if (!run_en) begin
         state_d = rlm_pkg::RUN_IDLE;
      end else begin
         unique case (state_q)
            rlm_pkg::RUN_IDLE,
            rlm_pkg::RUN_COUNT:   state_d = end_hit ? rlm_pkg::RUN_STOPPED : rlm_pkg::RUN_COUNT;
            rlm_pkg::RUN_STOPPED: state_d = rlm_pkg::RUN_STOPPED;
            default:              state_d = rlm_pkg::RUN_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= rlm_pkg::RUN_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   rlm_sat_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!run_en),
      .inc  (state_q != rlm_pkg::RUN_STOPPED),
      .count(cycle_count)
   );

   rlm_status_reg #(
      .DATA_W   (DATA_W),
      .PASS_WORD(PASS_WORD),
      .FAIL_WORD(FAIL_WORD)
   ) u_status (
      .clk  (clk),
      .rst_n(rst_n),
      .load (result_hit),
      .din  (wr_data),
      .word (status_word),
      .valid(status_valid),
      .pass (status_pass),
      .fail (status_fail)
   );

   assign done = (state_q == rlm_pkg::RUN_STOPPED);

endmodule

// File: rtl/run_len_monitor_chk.sv
module run_len_monitor_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [ADDR_W-1:0] END_ADDR = '0,
   parameter logic [DATA_W-1:0] END_WORD = '0,
   localparam int unsigned BE_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BE_W-1:0]   wr_be,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  cycle_count,
   input logic              done,
   input logic              status_valid,
   input logic              status_pass,
   input logic              status_fail
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !done && cycle_count != TOP) |=> (cycle_count == $past(cycle_count) + 1'b1));

   p_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && wr_en && (&wr_be) && wr_addr == END_ADDR && wr_data == END_WORD) |=> done);

   p_no_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !(wr_en && (&wr_be) && wr_addr == END_ADDR && wr_data == END_WORD)) |=> !done);

   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && run_en) |=> (done && $stable(cycle_count)));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cycle_count == '0 && !done));

   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && cycle_count == TOP) |=> (cycle_count == TOP));

   p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_pass && status_fail) && ((status_pass || status_fail) -> status_valid));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !done);

endmodule

bind run_len_monitor run_len_monitor_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CNT_W   (CNT_W),
   .END_ADDR(END_ADDR),
   .END_WORD(END_WORD)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_en      (run_en),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_be       (wr_be),
   .wr_data     (wr_data),
   .cycle_count (cycle_count),
   .done        (done),
   .status_valid(status_valid),
   .status_pass (status_pass),
   .status_fail (status_fail)
);

// File: tb/test_run_len_monitor.sv
module test_run_len_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_addr = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;

   logic [31:0] cycle_count;
   logic        done;
   logic [31:0] status_word;
   logic        status_valid, status_pass, status_fail;

   logic [4:0]  s_count;
   logic        s_done;
   logic [31:0] s_word;
   logic        s_valid, s_pass, s_fail;

   always #10 clk = ~clk;

   run_len_monitor i_run_len_monitor (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_be(wr_be), .wr_data(wr_data), .cycle_count(cycle_count), .done(done),
      .status_word(status_word), .status_valid(status_valid),
      .status_pass(status_pass), .status_fail(status_fail)
   );

   run_len_monitor #(.CNT_W(5)) i_run_len_monitor_narrow (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_be(wr_be), .wr_data(wr_data), .cycle_count(s_count), .done(s_done),
      .status_word(s_word), .status_valid(s_valid),
      .status_pass(s_pass), .status_fail(s_fail)
   );

   // reference model
   longint      m_cnt = 0;
   bit          m_done = 0;
   longint      m_cnt_s = 0;
   bit          m_done_s = 0;
   logic [31:0] m_word = '0;
   bit          m_valid = 0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string cur_req = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_cnt_s = 0; m_done_s = 0; m_word = '0; m_valid = 0;
      end else begin
         bit full, marker;
         full   = wr_en && (wr_be == 4'hF);
         marker = full && wr_addr == 32'h2000 && wr_data == 32'hDEADBEEF;
         if (!run_en) begin
            m_cnt = 0; m_done = 0; m_cnt_s = 0; m_done_s = 0;
         end else begin
            if (!m_done) begin
               if (m_cnt < 64'hFFFF_FFFF) m_cnt = m_cnt + 1;
               if (marker) m_done = 1;
            end
            if (!m_done_s) begin
               if (m_cnt_s < 31) m_cnt_s = m_cnt_s + 1;
               if (marker) m_done_s = 1;
            end
         end
         if (full && wr_addr == 32'h2004) begin
            m_word = wr_data; m_valid = 1;
         end
      end
   end

   task automatic chk(input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      chk("cycle_count", cycle_count, m_cnt);
      chk("done", done, m_done);
      chk("status_word", status_word, m_word);
      chk("status_valid", status_valid, m_valid);
      chk("status_pass", status_pass, m_valid && m_word == 32'hCADEBABE);
      chk("status_fail", status_fail, m_valid && m_word == 32'hBAAAAAAD);
      chk("narrow cycle_count", s_count, m_cnt_s);
      chk("narrow done", s_done, m_done_s);
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=done", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic drive(input bit en, input bit we, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] d, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         run_en = en; wr_en = we; wr_addr = a; wr_be = be; wr_data = d;
      end
   endtask

   initial begin
      cur_req = "R1";
      drive(0, 0, 0, 0, 0, 3);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, 2);
      cur_req = "R2";
      drive(1, 0, 0, 0, 0, 10);
      cur_req = "R4";
      drive(1, 0, 32'h2000, 4'hF, 32'hDEADBEEF, 2);
      drive(1, 1, 32'h2000, 4'h7, 32'hDEADBEEF, 1);
      drive(1, 1, 32'h2000, 4'hE, 32'hDEADBEEF, 1);
      drive(1, 1, 32'h2008, 4'hF, 32'hDEADBEEF, 1);
      drive(1, 1, 32'h2000, 4'hF, 32'hDEADBEEE, 1);
      drive(1, 1, 32'h1000, 4'hF, 32'h12345678, 2);
      cur_req = "R8";
      drive(1, 1, 32'h2004, 4'hF, 32'hBAAAAAAD, 1);
      cur_req = "R9";
      drive(1, 0, 0, 0, 0, 2);
      cur_req = "R8";
      drive(1, 1, 32'h2004, 4'h3, 32'hCADEBABE, 1);
      drive(1, 0, 0, 0, 0, 2);
      cur_req = "R9";
      drive(1, 1, 32'h2004, 4'hF, 32'hCADEBABE, 1);
      cur_req = "R7";
      drive(1, 0, 0, 0, 0, 20);
      cur_req = "R3";
      drive(1, 1, 32'h2000, 4'hF, 32'hDEADBEEF, 1);
      drive(1, 0, 0, 0, 0, 2);
      cur_req = "R5";
      drive(1, 1, 32'h2000, 4'hF, 32'hDEADBEEF, 1);
      drive(1, 0, 0, 0, 0, 5);
      cur_req = "R6";
      drive(0, 0, 0, 0, 0, 3);
      cur_req = "R10";
      drive(0, 1, 32'h2000, 4'hF, 32'hDEADBEEF, 1);
      drive(0, 0, 0, 0, 0, 2);
      cur_req = "R2";
      drive(1, 0, 0, 0, 0, 6);
      cur_req = "R3";
      drive(1, 1, 32'h2000, 4'hF, 32'hDEADBEEF, 1);
      drive(1, 0, 0, 0, 0, 4);
      cur_req = "R1";
      rst_n = 1'b0;
      drive(1, 0, 0, 0, 0, 2);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule